// File: doc/BRIEF.md
# Maskable Priority Interrupt Controller

This block holds one control byte per interrupt source and decides which pending request is offered to the processor. It has 24 sources. Sources 0 to 7 come from external pins. Each pin source chooses whether a rising or a falling edge raises its request. Sources 8 to 23 are internal, and each of them raises its request while its input line is high. A request sets a sticky flag in the source's control byte. Software may clear this flag through the register bus, but it can never set it.

Each source carries a 3-bit level. A level of zero keeps the source silent. Among the pending sources, the block chooses the one with the highest level; on a tie, the lowest source index wins. That source is offered on `irq_o` only when the global enable input is high and the source's level is strictly greater than the processor priority level input. The chosen index and its level are presented combinationally. When the processor pulses acknowledge, the flag of the chosen source is cleared, and the processor can load `lvl_o` as its new priority level.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every control byte reads 0x00 and `irq_o` is low.
- R2: Bits 2:0 of a control byte hold the level and read back as written. A source at level 0 never drives `irq_o`, even with its flag set.
- R3: Bit 3 is the request flag. Writing 0 to it clears the flag. Writing 1 to it leaves the flag unchanged.
- R4: On pin sources (addresses 0 to 7), bit 4 selects the active edge: 1 selects rising and 0 selects falling. An edge of the other direction does not set the flag.
- R5: Bits 7:5 always read 0. Bit 4 of an internal source always reads 0. Writes to these bits have no effect.
- R6: A pin edge sets the flag on the third rising clock edge after the pin changes (two synchronizer stages, then detection). An internal line that is high at a clock edge sets the flag at that edge.
- R7: If a request arrives in the same cycle as a software write that clears the flag, the flag ends set.
- R8: `irq_o` is high only when `ien_i` is 1, some pending source has a level strictly greater than `ipl_i`, and that source is the chosen one.
- R9: The chosen source has the highest level among the eligible sources. On equal levels, the lower index is chosen.
- R10: `vec_o` and `lvl_o` give the chosen source and its level. While `irq_o` is high, an `ack_i` pulse clears that source's flag at the next clock edge.
- R11: Source i is at bus address i (0 to 23). Addresses 24 and above read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register bus address |
| wr_i | input | 1 | Write strobe for the current cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| pin_irq_i | input | 8 | Asynchronous external request pins |
| int_irq_i | input | 16 | Internal request lines, active high |
| ien_i | input | 1 | Global maskable interrupt enable |
| ipl_i | input | 3 | Current processor priority level |
| ack_i | input | 1 | Acknowledge pulse from the processor |
| irq_o | output | 1 | Interrupt offered to the processor |
| vec_o | output | 5 | Index of the chosen source |
| lvl_o | output | 3 | Level of the chosen source |

## Verification
The hardest cases to reach are collisions inside a single clock cycle. One is a request that lands in the same cycle as a software clear of that flag. Another is an acknowledge that falls on a cycle where a second source of equal level is also pending. The bench produces both with internal request lines, because these set the flag one edge after they are driven. This lets a pulse be placed exactly on the cycle of a bus write or of an acknowledge. A behavioural model in the bench then follows every clock, including the three-stage delay of the pin path.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int DATA_W   = 8;
  localparam int LVL_W    = 3;
  localparam int FLAG_BIT = 3;
  localparam int POL_BIT  = 4;
endpackage

// File: rtl/irq_src.sv
module irq_src
  import irq_ctrl_pkg::*;
#(
  parameter bit HAS_POL = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [LVL_W-1:0]  wlvl_i,
  input  logic              wflag_i,
  input  logic              wpol_i,
  input  logic              req_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] cfg_o,
  output logic [LVL_W-1:0]  lvl_o,
  output logic              pend_o
);
  logic [LVL_W-1:0] lvl_q;
  logic             flag_q;
  logic             set_ev;
  logic             pol_bit;

  if (HAS_POL) begin : g_pin
    logic s1_q, s2_q, prev_q, pol_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
        pol_q  <= 1'b0;
      end else begin
        s1_q   <= req_i;
        s2_q   <= s1_q;
        prev_q <= s2_q;
        if (we_i) pol_q <= wpol_i;
      end
    end
    // rising when pol=1, falling when pol=0
    assign set_ev  = pol_q ? (s2_q & ~prev_q) : (~s2_q & prev_q);
    assign pol_bit = pol_q;
  end else begin : g_int
    logic unused_pol;
    assign unused_pol = wpol_i;
    assign set_ev     = req_i;
    assign pol_bit    = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (we_i) lvl_q <= wlvl_i;
      // a new request beats any clear in the same cycle
      flag_q <= set_ev | (flag_q & ~(we_i & ~wflag_i) & ~ack_i);
    end
  end

  assign cfg_o  = {{(DATA_W-POL_BIT-1){1'b0}}, pol_bit, flag_q, lvl_q};
  assign lvl_o  = lvl_q;
  assign pend_o = flag_q;

  p_req_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ev |=> flag_q);
  p_sw_no_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !flag_q && !set_ev) |=> !flag_q);
  p_ack_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !set_ev) |=> !flag_q);
  p_flag_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !ack_i && !set_ev) |=> $stable(flag_q));
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int N     = 24,
  parameter int LVL_W = 3,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            pend_i,
  input  logic [N-1:0][LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0]        ipl_i,
  input  logic                    ien_i,
  output logic                    irq_o,
  output logic [IDX_W-1:0]        vec_o,
  output logic [LVL_W-1:0]        lvl_o
);
  logic             found;
  logic [LVL_W-1:0] best_lvl;
  logic [IDX_W-1:0] best_idx;

  // ascending scan, strict compare: lowest index keeps a tie
  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i] && (lvl_i[i] > ipl_i) && (!found || (lvl_i[i] > best_lvl))) begin
        found    = 1'b1;
        best_lvl = lvl_i[i];
        best_idx = IDX_W'(i);
      end
    end
  end

  assign irq_o = ien_i & found;
  assign vec_o = best_idx;
  assign lvl_o = best_lvl;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int N_PIN  = 8,
  parameter int N_INT  = 16,
  parameter int ADDR_W = 5,
  localparam int N_SRC = N_PIN + N_INT,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_PIN-1:0]  pin_irq_i,
  input  logic [N_INT-1:0]  int_irq_i,
  input  logic              ien_i,
  input  logic [LVL_W-1:0]  ipl_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [IDX_W-1:0]  vec_o,
  output logic [LVL_W-1:0]  lvl_o
);
  logic [N_SRC-1:0][DATA_W-1:0] cfg;
  logic [N_SRC-1:0][LVL_W-1:0]  lvl;
  logic [N_SRC-1:0]             pend;
  logic [N_SRC-1:0]             hit;
  logic [N_SRC-1:0]             ack_src;
  logic [N_SRC-1:0]             req;
  logic [DATA_W-POL_BIT-2:0]    unused_wdata;

  assign unused_wdata = wdata_i[DATA_W-1:POL_BIT+1];
  assign req = {int_irq_i, pin_irq_i};

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit[i]     = wr_i && (addr_i == ADDR_W'(i));
    assign ack_src[i] = ack_i && irq_o && (vec_o == IDX_W'(i));
    irq_src #(.HAS_POL(i < N_PIN)) u_src (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (hit[i]),
      .wlvl_i (wdata_i[LVL_W-1:0]),
      .wflag_i(wdata_i[FLAG_BIT]),
      .wpol_i (wdata_i[POL_BIT]),
      .req_i  (req[i]),
      .ack_i  (ack_src[i]),
      .cfg_o  (cfg[i]),
      .lvl_o  (lvl[i]),
      .pend_o (pend[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_SRC; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = cfg[i];
  end

  irq_arb #(.N(N_SRC), .LVL_W(LVL_W)) u_arb (
    .pend_i(pend),
    .lvl_i (lvl),
    .ipl_i (ipl_i),
    .ien_i (ien_i),
    .irq_o (irq_o),
    .vec_o (vec_o),
    .lvl_o (lvl_o)
  );

  p_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ien_i && (lvl_o > ipl_i)));
  p_grant_pending_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend[vec_o] && (lvl[vec_o] == lvl_o)));
  p_one_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_src));
endmodule

// File: tb/sim_irq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [7:0]  pin = '0;
  logic [15:0] intr = '0;
  logic        ien = 1'b0;
  logic [2:0]  ipl = '0;
  logic        ack = 1'b0;
  logic        irq;
  logic [4:0]  vec;
  logic [2:0]  lvl;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_irq_i(pin), .int_irq_i(intr), .ien_i(ien),
    .ipl_i(ipl), .ack_i(ack), .irq_o(irq), .vec_o(vec), .lvl_o(lvl)
  );

  // behavioural reference
  int m_lvl[24];
  bit m_flg[24];
  bit m_pol[8];
  bit m_s1[8], m_s2[8], m_pv[8];
  bit m_ev[24];

  function automatic int m_win();
    int b = -1;
    if (!ien) return -1;
    for (int i = 0; i < 24; i++)
      if (m_flg[i] && m_lvl[i] > int'(ipl) && (b < 0 || m_lvl[i] > m_lvl[b])) b = i;
    return b;
  endfunction

  function automatic int m_read(int a);
    if (a >= 24) return 0;
    return m_lvl[a] + (m_flg[a] ? 8 : 0) + ((a < 8 && m_pol[a]) ? 16 : 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 24; i++) begin m_lvl[i] = 0; m_flg[i] = 0; end
      for (int i = 0; i < 8; i++) begin m_pol[i] = 0; m_s1[i] = 0; m_s2[i] = 0; m_pv[i] = 0; end
    end else begin
      int w;
      w = m_win();
      for (int i = 0; i < 8; i++) begin
        m_ev[i] = m_pol[i] ? (m_s2[i] && !m_pv[i]) : (!m_s2[i] && m_pv[i]);
        m_pv[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = pin[i];
      end
      for (int i = 8; i < 24; i++) m_ev[i] = intr[i-8];
      if (wr && int'(addr) < 24) begin
        m_lvl[addr] = int'(wdata[2:0]);
        if (addr < 8) m_pol[addr] = wdata[4];
        if (!wdata[3]) m_flg[addr] = 0;
      end
      if (ack && w >= 0) m_flg[w] = 0;
      for (int i = 0; i < 24; i++) if (m_ev[i]) m_flg[i] = 1;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      int w;
      w = m_win();
      chk(irq == (w >= 0), "R8 irq_o vs model", int'(irq), int'(w >= 0));
      if (w >= 0) begin
        chk(int'(vec) == w, "R9 vec_o vs model", int'(vec), w);
        chk(int'(lvl) == m_lvl[w], "R10 lvl_o vs model", int'(lvl), m_lvl[w]);
      end
      chk(int'(rdata) == m_read(int'(addr)), "R11 rdata_o vs model", int'(rdata), m_read(int'(addr)));
    end
  end

  task automatic wr_reg(int a, int d);
    @(negedge clk); addr = 5'(a); wdata = 8'(d); wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd(int a, int exp, string tag);
    @(negedge clk); wr = 1'b0; addr = 5'(a);
    #1 chk(int'(rdata) == exp, tag, int'(rdata), exp);
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(bit e, int v, int l, string tag);
    #1;
    chk(irq == e, tag, int'(irq), int'(e));
    if (e) begin
      chk(int'(vec) == v, tag, int'(vec), v);
      chk(int'(lvl) == l, tag, int'(lvl), l);
    end
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  initial begin
    waitn(3);
    rst_n = 1'b1;
    rd(0, 8'h00, "R1 reset byte src0");
    rd(23, 8'h00, "R1 reset byte src23");
    chk_irq(0, 0, 0, "R1 irq low after reset");

    wr_reg(2, 8'h1D);
    rd(2, 8'h15, "R3 write of flag=1 does not set");
    wr_reg(3, 8'hFF);
    rd(3, 8'h17, "R5 upper bits of pin source");
    wr_reg(3, 8'h00);
    wr_reg(10, 8'hFF);
    rd(10, 8'h07, "R5 polarity bit absent on internal source");
    wr_reg(10, 8'h00);
    wr_reg(30, 8'h07);
    rd(30, 8'h00, "R11 unmapped address");

    ien = 1'b1; ipl = 3'd0;
    @(negedge clk); pin[2] = 1'b1;
    waitn(2); chk_irq(0, 0, 0, "R6 not yet set after two edges");
    waitn(1); chk_irq(1, 2, 5, "R6 pin edge sets on third edge");

    @(negedge clk); ipl = 3'd5; chk_irq(0, 0, 0, "R8 level equal to ipl blocked");
    @(negedge clk); ipl = 3'd4; chk_irq(1, 2, 5, "R8 level above ipl offered");
    @(negedge clk); ien = 1'b0; chk_irq(0, 0, 0, "R8 global enable low");
    @(negedge clk); ien = 1'b1; ipl = 3'd0;

    pulse_ack();
    rd(2, 8'h15, "R10 ack clears granted flag");
    chk_irq(0, 0, 0, "R10 nothing pending after ack");

    @(negedge clk); pin[2] = 1'b0;
    waitn(5);
    rd(2, 8'h15, "R4 falling edge ignored on rising source");

    wr_reg(5, 8'h03);
    @(negedge clk); pin[5] = 1'b1;
    waitn(5);
    rd(5, 8'h03, "R4 rising edge ignored on falling source");
    @(negedge clk); pin[5] = 1'b0;
    waitn(5);
    rd(5, 8'h0B, "R4 falling edge sets flag");
    chk_irq(1, 5, 3, "R4 pin 5 offered");

    wr_reg(10, 8'h07);
    wr_reg(12, 8'h07);
    @(negedge clk); intr[2] = 1'b1; intr[4] = 1'b1;
    @(negedge clk); intr = '0;
    chk_irq(1, 10, 7, "R6 internal sets after one edge; R9 tie to lower index");
    pulse_ack();
    chk_irq(1, 12, 7, "R9 next equal level after ack");
    pulse_ack();
    chk_irq(1, 5, 3, "R9 lower level after higher served");

    @(negedge clk); addr = 5'd12; wdata = 8'h07; wr = 1'b1; intr[4] = 1'b1;
    @(negedge clk); wr = 1'b0; intr = '0;
    rd(12, 8'h0F, "R7 request beats same-cycle clear");
    chk_irq(1, 12, 7, "R7 source offered");

    wr_reg(12, 8'h08);
    rd(12, 8'h08, "R2 level 0 keeps flag");
    chk_irq(1, 5, 3, "R2 level 0 source not offered");
    wr_reg(5, 8'h00);
    rd(5, 8'h00, "R3 write 0 clears flag");
    chk_irq(0, 0, 0, "R2 only level 0 source pending");

    waitn(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule